// File: doc/BRIEF.md
# Compare Timer with Hardware PWM Pins

This block is a free-standing timer built around a counter and a set of compare channels. Channel 0 holds the period or reference value. The other channels each hold a compare value of their own. The counter runs in one of two ways:

- **Continuous mode:** the counter runs freely through its full range and wraps to zero. Software produces equally spaced events by moving a compare value forward by a fixed step after each match.
- **Up mode:** the counter restarts after it reaches the channel 0 value, so channel 0 sets the period and each further channel sets the duty of its own pin.

Every channel latches a sticky flag on a match. It raises its interrupt line only while its enable bit is set. Every channel also drives its own output pin from hardware through a selectable output mode. A PWM waveform is therefore produced without any software action and without interrupt latency.

All configuration goes through a single write port. Address 0 is the timer control word:

- bit 0: run
- bit 1: up mode
- bit 2: clear the counter

Channel k has two addresses:

- Address 1+2k holds its compare value.
- Address 2+2k holds its configuration word:
  - bit 0: interrupt enable
  - bits 2:1: output mode, where 0 drives the pin low, 1 selects toggle, 2 selects reset/set and 3 drives the pin low
  - bit 3: a write of 1 clears the flag

A `tick` input gates every count step.

Top module: `tcu_top`

## Requirements
- R1: After reset the counter reads 0 and every `irq` and `pwm` bit is 0.
- R2: In continuous mode (run=1, up=0) each cycle with `tick`=1 advances `count` by 1, and the largest value is followed by 0.
- R3: In up mode (run=1, up=1) `count` goes from 0 to the channel 0 compare value inclusive and then to 0, so the period is that value plus 1 ticks.
- R4: A tick in which `count` equals a channel's compare value sets that channel's flag. `irq[k]` is high exactly while flag k and enable k are both set, so a flag latched while the enable was 0 appears as soon as the enable is written to 1.
- R5: A flag stays set until a configuration write with bit 3 = 1 clears it. If that write coincides with a match, the flag stays set.
- R6: In reset/set mode (code 2) the pin goes high after a tick where `count` equals the channel 0 value, and it goes low after a tick where `count` equals the channel's own value. When both match, high wins. In up mode the pin is high for (own value + 1) of every (period value + 1) ticks.
- R7: In toggle mode (code 1) the pin inverts after each tick where `count` equals the channel's own compare value.
- R8: With output mode 0 the pin reads 0 from the cycle after the configuration write and ignores matches.
- R9: While `tick` is 0 the counter holds, and no flag or pin changes.
- R10: A written compare value is used from the next clock edge on. The edge that performs the write still compares against the old value.
- R11: A control write with bit 2 = 1 sets `count` to 0 on that edge, even while the counter is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one count step per cycle when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| irq | output | N_CH | Per-channel interrupt lines |
| pwm | output | N_CH | Per-channel output pins |

## Verification
The bench builds the block with an 8-bit counter, three channels and a 3-bit address. With an 8-bit counter, the continuous-mode wrap at 255 is reached within a few hundred cycles. Three channels let channel 0, a toggle channel and a reset/set channel run against the same period at once. A short up-mode period of ten ticks brings the coincidences within reach in a few cycles: a flag clear that lands on a match, a duty equal to the period, and a period shortened while the counter is already past the new value.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

   // pin behaviour codes held in bits 2:1 of a channel configuration word
   typedef enum logic [1:0] {
      OM_LOW    = 2'd0,
      OM_TOGGLE = 2'd1,
      OM_RSTSET = 2'd2,
      OM_LOW2   = 2'd3
   } outmode_t;

   // timer control word bit positions
   localparam int CTL_RUN = 0;
   localparam int CTL_UP  = 1;
   localparam int CTL_CLR = 2;

   // channel configuration word bit positions
   localparam int CFG_IE    = 0;
   localparam int CFG_MODE  = 1;
   localparam int CFG_FCLR  = 3;

endpackage

// File: rtl/tcu_counter.sv
module tcu_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             up,
   input  logic             clr,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (step) begin
         if (up && (cnt_q >= period)) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/tcu_channel.sv
module tcu_channel
   import tcu_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] count,
   input  logic             base_hit,
   input  logic             cmp_we,
   input  logic             cfg_we,
   input  logic             flag_clr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cmp_o,
   output outmode_t         mode_o,
   output logic             flag_o,
   output logic             out_o,
   output logic             irq,
   output logic             pin
);

   logic [CNT_W-1:0] cmp_q;
   outmode_t         mode_q;
   logic             ie_q;
   logic             flag_q;
   logic             out_q;
   logic             own_hit;

   assign own_hit = step && (count == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         mode_q <= OM_LOW;
         ie_q   <= 1'b0;
      end else begin
         if (cmp_we) begin
            cmp_q <= wdata;
         end
         if (cfg_we) begin
            ie_q   <= wdata[CFG_IE];
            mode_q <= outmode_t'(wdata[CFG_MODE +: 2]);
         end
      end
   end

   // match has priority over a clear arriving on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (own_hit) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else begin
         unique case (mode_q)
            OM_TOGGLE: if (own_hit) out_q <= ~out_q;
            OM_RSTSET: begin
               if (base_hit) begin
                  out_q <= 1'b1;
               end else if (own_hit) begin
                  out_q <= 1'b0;
               end
            end
            default:   out_q <= 1'b0;
         endcase
      end
   end

   assign irq    = flag_q && ie_q;
   assign pin    = out_q && (mode_q == OM_TOGGLE || mode_q == OM_RSTSET);
   assign cmp_o  = cmp_q;
   assign mode_o = mode_q;
   assign flag_o = flag_q;
   assign out_o  = out_q;

endmodule

// File: rtl/tcu_top.sv
module tcu_top
   import tcu_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_CH   = 3,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count,
   output logic [N_CH-1:0]   irq,
   output logic [N_CH-1:0]   pwm
);

   localparam int N_REG  = 1 + 2 * N_CH;
   localparam int MIN_AW = $clog2(N_REG);

   if (CNT_W < 4) begin : g_bad_cnt_w
      $error("tcu_top: CNT_W must be at least 4 to hold a configuration word");
   end
   if (N_CH < 2) begin : g_bad_n_ch
      $error("tcu_top: N_CH must include channel 0 and one further channel");
   end
   if (ADDR_W < MIN_AW) begin : g_bad_addr_w
      $error("tcu_top: ADDR_W too small for the channel count");
   end

   logic                         run_q;
   logic                         up_q;
   logic                         ctl_we;
   logic                         clr_req;
   logic                         step;
   logic                         base_hit;
   logic [N_CH-1:0][CNT_W-1:0]   ch_cmp;
   logic [N_CH-1:0][1:0]         ch_mode;
   logic [N_CH-1:0]              ch_flag;
   logic [N_CH-1:0]              ch_out;
   logic [N_CH-1:0]              ch_fclr;

   assign ctl_we   = wr_en && (wr_addr == '0);
   assign clr_req  = ctl_we && wr_data[CTL_CLR];
   assign step     = run_q && tick;
   assign base_hit = step && (count == ch_cmp[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         up_q  <= 1'b0;
      end else if (ctl_we) begin
         run_q <= wr_data[CTL_RUN];
         up_q  <= wr_data[CTL_UP];
      end
   end

   tcu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .up     (up_q),
      .clr    (clr_req),
      .period (ch_cmp[0]),
      .count  (count)
   );

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      logic     cmp_we;
      logic     cfg_we;
      outmode_t mode;

      assign cmp_we     = wr_en && (wr_addr == ADDR_W'(1 + 2 * k));
      assign cfg_we     = wr_en && (wr_addr == ADDR_W'(2 + 2 * k));
      assign ch_fclr[k] = cfg_we && wr_data[CFG_FCLR];
      assign ch_mode[k] = mode;

      tcu_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .step     (step),
         .count    (count),
         .base_hit (base_hit),
         .cmp_we   (cmp_we),
         .cfg_we   (cfg_we),
         .flag_clr (ch_fclr[k]),
         .wdata    (wr_data),
         .cmp_o    (ch_cmp[k]),
         .mode_o   (mode),
         .flag_o   (ch_flag[k]),
         .out_o    (ch_out[k]),
         .irq      (irq[k]),
         .pin      (pwm[k])
      );
   end

endmodule

// File: rtl/tcu_chk.sv
module tcu_chk
   import tcu_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_CH   = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tick,
   input logic                       clr,
   input logic                       run,
   input logic                       up,
   input logic [CNT_W-1:0]           count,
   input logic [N_CH-1:0][CNT_W-1:0] ch_cmp,
   input logic [N_CH-1:0][1:0]       ch_mode,
   input logic [N_CH-1:0]            ch_flag,
   input logic [N_CH-1:0]            ch_fclr,
   input logic [N_CH-1:0]            ch_out
);

   // R2
   cont_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !up && !clr) |=> (count == CNT_W'($past(count) + 1'b1)));

   // R3
   up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && up && !clr && (count >= ch_cmp[0])) |=> (count == '0));

   // R9
   tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(count));

   // R11
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

   for (genvar k = 0; k < N_CH; k++) begin : g_c
      // R4
      flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_flag[k]) |-> $past(run && tick && (count == ch_cmp[k])));

      // R5
      flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_flag[k] && !ch_fclr[k]) |=> ch_flag[k]);

      // R6
      rs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_mode[k] == 2'(OM_RSTSET) && run && tick && (count == ch_cmp[0])) |=> ch_out[k]);

      // R7
      toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_mode[k] == 2'(OM_TOGGLE) && run && tick && (count == ch_cmp[k]))
         |=> (ch_out[k] != $past(ch_out[k])));

      // R8
      low_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_mode[k] == 2'(OM_LOW)) |=> !ch_out[k]);
   end

endmodule

bind tcu_top tcu_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .clr     (clr_req),
   .run     (run_q),
   .up      (up_q),
   .count   (count),
   .ch_cmp  (ch_cmp),
   .ch_mode (ch_mode),
   .ch_flag (ch_flag),
   .ch_fclr (ch_fclr),
   .ch_out  (ch_out)
);

// File: tb/test_tcu_top.sv
module test_tcu_top;

   localparam int CNT_W  = 8;
   localparam int N_CH   = 3;
   localparam int ADDR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b1;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [CNT_W-1:0]  count;
   logic [N_CH-1:0]   irq;
   logic [N_CH-1:0]   pwm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tcu_top #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) i_tcu_top (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .count   (count),
      .irq     (irq),
      .pwm     (pwm)
   );

   task automatic expect_eq(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // entered and left just after a falling edge
   task automatic wr(int addr, int data);
      wr_en   = 1'b1;
      wr_addr = ADDR_W'(addr);
      wr_data = CNT_W'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      step(2);
      rst_n = 1'b1;
      step(1);
      expect_eq("R1 count", int'(count), 0);
      expect_eq("R1 irq", int'(irq), 0);
      expect_eq("R1 pwm", int'(pwm), 0);
   endtask

   task automatic t_continuous();
      wr(0, 5);                                   // run, continuous, clear
      expect_eq("R11 clear on start", int'(count), 0);
      step(5);
      expect_eq("R2 count 5", int'(count), 5);
      step(250);
      expect_eq("R2 count max", int'(count), 255);
      step(1);
      expect_eq("R2 wrap to 0", int'(count), 0);
      step(10);
      wr(0, 5);
      expect_eq("R11 clear while running", int'(count), 0);
   endtask

   task automatic t_up();
      wr(0, 0);
      wr(1, 9);                                   // period value
      wr(0, 7);                                   // run, up, clear
      step(9);
      expect_eq("R3 reaches period value", int'(count), 9);
      step(1);
      expect_eq("R3 returns to 0", int'(count), 0);
      step(13);
      expect_eq("R3 second period", int'(count), 3);
   endtask

   task automatic t_outputs();
      wr(0, 0);
      wr(3, 3);                                   // ch1 compare
      wr(4, 11);                                  // ch1 toggle, ie, clear flag
      wr(5, 4);                                   // ch2 compare
      wr(6, 12);                                  // ch2 reset/set, no ie, clear flag
      wr(0, 7);
      expect_eq("R1 pins low at start", int'(pwm), 0);
      step(3);
      expect_eq("R7 before match", int'(pwm[1]), 0);
      expect_eq("R4 no irq before match", int'(irq[1]), 0);
      step(1);                                    // count 4
      expect_eq("R7 toggled high", int'(pwm[1]), 1);
      expect_eq("R4 irq on match", int'(irq[1]), 1);
      step(1);                                    // count 5
      expect_eq("R4 masked flag", int'(irq[2]), 0);
      step(5);                                    // count 0
      expect_eq("R6 set at period", int'(pwm[2]), 1);
      step(4);                                    // count 4
      expect_eq("R6 still high", int'(pwm[2]), 1);
      expect_eq("R7 toggled low", int'(pwm[1]), 0);
      step(1);                                    // count 5
      expect_eq("R6 reset at own match", int'(pwm[2]), 0);
      wr(6, 5);                                   // enable ch2 irq, keep mode
      expect_eq("R4 latched flag shows", int'(irq[2]), 1);
      wr(6, 13);                                  // clear ch2 flag, count 7 after
      expect_eq("R5 flag cleared", int'(irq[2]), 0);
      expect_eq("R5 other flag kept", int'(irq[1]), 1);
      step(6);                                    // count 3
      expect_eq("R5 sync count", int'(count), 3);
      wr(4, 11);                                  // clear on the matching edge
      expect_eq("R5 match beats clear", int'(irq[1]), 1);
      wr(4, 11);                                  // count 5 after
      expect_eq("R5 clear off match", int'(irq[1]), 0);
      expect_eq("R7 third toggle", int'(pwm[1]), 1);
      wr(4, 0);                                   // ch1 pin low mode
      expect_eq("R8 pin low after write", int'(pwm[1]), 0);
      step(8);                                    // passes a ch1 match
      expect_eq("R8 match ignored", int'(pwm[1]), 0);
   endtask

   task automatic t_set_wins();
      wr(0, 0);
      wr(5, 9);                                   // ch2 duty equals period
      wr(0, 7);
      step(10);
      expect_eq("R6 high when both match", int'(pwm[2]), 1);
      step(10);
      expect_eq("R6 stays high", int'(pwm[2]), 1);
   endtask

   task automatic t_late_period();
      step(4);                                    // count 4
      expect_eq("R10 sync count", int'(count), 4);
      wr(1, 2);                                   // old period used on this edge
      expect_eq("R10 old value on write edge", int'(count), 5);
      step(1);
      expect_eq("R10 new value next edge", int'(count), 0);
      step(3);
      expect_eq("R10 new period", int'(count), 0);
   endtask

   task automatic t_tick();
      logic [N_CH-1:0] pwm_b;
      logic [N_CH-1:0] irq_b;
      step(1);                                    // count 1
      pwm_b = pwm;
      irq_b = irq;
      tick = 1'b0;
      step(5);
      expect_eq("R9 count held", int'(count), 1);
      expect_eq("R9 pins held", int'(pwm), int'(pwm_b));
      expect_eq("R9 irqs held", int'(irq), int'(irq_b));
      tick = 1'b1;
      step(1);
      expect_eq("R9 resumes", int'(count), 2);
   endtask

   initial begin
      t_reset();
      t_continuous();
      t_up();
      t_outputs();
      t_set_wins();
      t_late_period();
      t_tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule